// File: doc/BRIEF.md
# Power-of-Two Clock Post-Divider with Glitch-Free Output Enable

This block turns a fast input clock into a slower output clock by a factor of 1, 2, 4 or 8. A 2-bit select picks the factor. The output is a registered signal in the input clock domain. For each factor of two or more it is a square wave: high for the first half of every period and low for the second half. For a factor of one it is a one-bit qualifier that stays high for every input cycle while the output runs.

An active-high enable starts and stops the output. The block samples the enable, and also the divide select, only where one output period ends and the next begins. A high phase is therefore never cut short, and a first high phase is never shortened. While stopped, the output rests low. The internal period counter keeps running while the output is stopped, so a restart lines up with the period grid that is already running.

A typical use is the post-divider behind a frequency synthesizer. There the enable lets downstream logic pause its clock without producing runt pulses. The select lets the output band be chosen. With an input of 200 to 400 MHz, the four factors give 200–400, 100–200, 50–100 and 25–50 MHz.

Top module: `pdiv_post_div`

## Requirements
- R1: While `rst_n` is low, `clk_out` is low. After reset is released, the first rising clock edge starts a new output period and samples `div_sel` and `out_en`.
- R2: `div_sel` codes 01, 10 and 11 select divide-by-2, 4 and 8. For a ratio N, `clk_out` repeats every N input cycles and is high for the first N/2 cycles of each period.
- R3: `div_sel` code 00 selects divide-by-1. In this mode `clk_out` is high on every cycle in which the output runs, and it follows `out_en` with one register delay.
- R4: Once a low `out_en` has taken effect, `clk_out` stays low for as long as `out_en` stays low.
- R5: Dropping `out_en` never shortens a high phase. The current period, high and low parts alike, completes before the output stops.
- R6: `out_en` is sampled only at a period boundary. Raising it in mid-period makes the output start at the next boundary with a full-width high phase. A low pulse on `out_en` that begins and ends within one period has no effect.
- R7: A change of `div_sel` takes effect at the next period boundary. The remainder of the current period keeps the old ratio, and the new ratio starts from the beginning of its period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Ratio code: 00 ÷1, 01 ÷2, 10 ÷4, 11 ÷8 |
| out_en | input | 1 | Active-high output enable, applied at period boundaries |
| clk_out | output | 1 | Divided, enable-qualified output (registered) |

## Verification
On every cycle, the bound checker confirms four things. The phase counter stays inside the active period. The latched ratio and the run state change only right after a boundary. Rising output edges fall at the start of a period. Falling edges fall either at the half-period point or at a boundary where the output stops, and the output is always low when a boundary of a divided period is reached. Only the bench scenarios can show the exact waveform for each select code. They also show which boundary a mid-period enable, disable or select change lands on, and that a short enable dip inside a period leaves the output untouched.

// File: rtl/pdiv_pkg.sv
`timescale 1ns/1ps
package pdiv_pkg;

    // Width of the ratio select code; ratio = 2**code.
    localparam int SEL_W = 2;
    // Phase counter width covers the largest ratio, 2**(2**SEL_W - 1).
    localparam int PH_W  = (1 << SEL_W) - 1;

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [PH_W-1:0]  phase_t;

    typedef enum logic [SEL_W-1:0] {
        RATIO_1 = 2'b00,
        RATIO_2 = 2'b01,
        RATIO_4 = 2'b10,
        RATIO_8 = 2'b11
    } ratio_code_e;

    // Decoded ratio: index of the last phase, and length of the high phase.
    typedef struct packed {
        phase_t last;
        phase_t hi;
    } ratio_t;

    // Period counter state.
    typedef struct packed {
        phase_t ph;
        ratio_t ratio;
    } ctr_t;

    // Output gating state.
    typedef struct packed {
        logic run;
        logic out;
    } gate_t;

    // Divide-by-1 decode: one-phase period, the phase counts as high.
    localparam ratio_t RATIO_RST = '{last: '0, hi: phase_t'(1)};

endpackage

// File: rtl/pdiv_ratio_dec.sv
`timescale 1ns/1ps
module pdiv_ratio_dec
    import pdiv_pkg::*;
(
    input  sel_t   sel,
    output ratio_t info
);

    logic [PH_W:0] span;

    always_comb begin
        span      = {{PH_W{1'b0}}, 1'b1} << sel;
        info.last = span[PH_W-1:0] - phase_t'(1);
        info.hi   = (sel == sel_t'(RATIO_1)) ? phase_t'(1) : span[PH_W:1];
    end

endmodule

// File: rtl/pdiv_phase_ctr.sv
`timescale 1ns/1ps
module pdiv_phase_ctr
    import pdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  ratio_t ratio_in,
    output logic   wrap,
    output phase_t ph_d_o,
    output phase_t hi_d_o,
    output phase_t ph_q_o,
    output ratio_t ratio_q_o
);

    ctr_t state_q;
    ctr_t state_d;

    always_comb begin
        state_d = state_q;
        wrap    = (state_q.ph >= state_q.ratio.last);
        if (wrap) begin
            state_d.ph    = '0;
            state_d.ratio = ratio_in;
        end else begin
            state_d.ph    = state_q.ph + phase_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{ph: '0, ratio: RATIO_RST};
        end else begin
            state_q <= state_d;
        end
    end

    assign ph_d_o    = state_d.ph;
    assign hi_d_o    = state_d.ratio.hi;
    assign ph_q_o    = state_q.ph;
    assign ratio_q_o = state_q.ratio;

endmodule

// File: rtl/pdiv_out_gate.sv
`timescale 1ns/1ps
module pdiv_out_gate
    import pdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wrap,
    input  logic   en,
    input  phase_t ph_d,
    input  phase_t hi_d,
    output logic   run_q_o,
    output logic   out_q_o
);

    gate_t state_q;
    gate_t state_d;

    always_comb begin
        state_d     = state_q;
        if (wrap) begin
            state_d.run = en;
        end
        state_d.out = state_d.run && (ph_d < hi_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign run_q_o = state_q.run;
    assign out_q_o = state_q.out;

endmodule

// File: rtl/pdiv_post_div.sv
`timescale 1ns/1ps
module pdiv_post_div
    import pdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             out_en,
    output logic             clk_out
);

    ratio_t sel_info;
    ratio_t ratio_q;
    phase_t ph_d;
    phase_t hi_d;
    phase_t ph_q;
    logic   wrap;
    logic   run_q;

    pdiv_ratio_dec u_dec (
        .sel  (div_sel),
        .info (sel_info)
    );

    pdiv_phase_ctr u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ratio_in  (sel_info),
        .wrap      (wrap),
        .ph_d_o    (ph_d),
        .hi_d_o    (hi_d),
        .ph_q_o    (ph_q),
        .ratio_q_o (ratio_q)
    );

    pdiv_out_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap    (wrap),
        .en      (out_en),
        .ph_d    (ph_d),
        .hi_d    (hi_d),
        .run_q_o (run_q),
        .out_q_o (clk_out)
    );

endmodule

// File: rtl/pdiv_post_div_chk.sv
`timescale 1ns/1ps
module pdiv_post_div_chk
    import pdiv_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   clk_out,
    input logic   wrap,
    input phase_t ph_q,
    input ratio_t ratio_q,
    input logic   run_q
);

    // R1: output low while reset is held
    p_reset_low_r1: assert property (@(posedge clk) !rst_n |-> !clk_out);

    // R2: phase never leaves the active period
    p_phase_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q <= ratio_q.last);

    // R7: latched ratio changes only right after a boundary
    p_ratio_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wrap) |-> $stable(ratio_q));

    // R6: run state changes only right after a boundary
    p_run_at_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(run_q) |-> $past(wrap));

    // R6: output rises only at the start of a period
    p_rise_at_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_out) |-> (ph_q == '0));

    // R5: output falls at half period, or at a boundary where it stops
    p_fall_point_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_out) |-> ((ph_q == ratio_q.hi) || ((ph_q == '0) && !run_q)));

    // R5: a divided period always ends in its low phase
    p_wrap_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && (ratio_q.last != '0)) |-> !clk_out);

endmodule

bind pdiv_post_div pdiv_post_div_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_out (clk_out),
    .wrap    (wrap),
    .ph_q    (ph_q),
    .ratio_q (ratio_q),
    .run_q   (run_q)
);

// File: tb/pdiv_post_div_tb.sv
`timescale 1ns/1ps
module pdiv_post_div_tb_top;

    localparam real T_CLK = 4.0;
    localparam int  WATCHDOG_CYC = 20000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] div_sel;
    logic       out_en;
    logic       clk_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(T_CLK/2.0) clk = ~clk;

    pdiv_post_div dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .out_en  (out_en),
        .clk_out (clk_out)
    );

    // Advance one rising edge and settle before sampling or driving.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic exp, input string tag, input int step);
        total++;
        if (clk_out !== exp) begin
            bad++;
            $display("FAIL %s: step %0d clk_out=%0b expected=%0b", tag, step, clk_out, exp);
        end
    endtask

    // Expected level at position pos (0-based) of a ratio-n period grid.
    function automatic logic wave(input int n, input int pos);
        int hi;
        hi = (n == 1) ? 1 : n / 2;
        return ((pos % n) < hi);
    endfunction

    // R1: reset holds output low; release just after an edge.
    task automatic do_reset(input logic [1:0] sel, input logic en);
        rst_n   = 1'b0;
        div_sel = sel;
        out_en  = en;
        repeat (3) begin
            tick();
            check(1'b0, "R1", 0);
        end
        rst_n = 1'b1;
    endtask

    // R2 / R3: steady waveform for every select code.
    task automatic t_ratio(input logic [1:0] sel);
        int n;
        n = 1 << sel;
        do_reset(sel, 1'b1);
        for (int k = 1; k <= 3 * n + 2; k++) begin
            tick();
            check(wave(n, k - 1), (sel == 2'b00) ? "R3" : "R2", k);
        end
    endtask

    // R5 / R4: disable during the high phase of divide-by-8.
    task automatic t_disable_high();
        do_reset(2'b11, 1'b1);
        tick(); tick();
        out_en = 1'b0;
        for (int k = 3; k <= 20; k++) begin
            tick();
            check(k <= 4, (k <= 8) ? "R5" : "R4", k);
        end
    endtask

    // R4: disable during the low phase, output remains low.
    task automatic t_disable_low();
        do_reset(2'b11, 1'b1);
        for (int k = 1; k <= 6; k++) begin
            tick();
            check(wave(8, k - 1), "R2", k);
        end
        out_en = 1'b0;
        for (int k = 7; k <= 24; k++) begin
            tick();
            check(1'b0, "R4", k);
        end
    endtask

    // R6: enable raised mid-period waits for the boundary.
    task automatic t_enable_mid();
        do_reset(2'b11, 1'b0);
        for (int k = 1; k <= 3; k++) begin
            tick();
            check(1'b0, "R4", k);
        end
        out_en = 1'b1;
        for (int k = 4; k <= 24; k++) begin
            tick();
            check((k >= 9) && wave(8, k - 1), "R6", k);
        end
    endtask

    // R6: a short enable dip inside one period is ignored.
    task automatic t_enable_dip();
        do_reset(2'b10, 1'b1);
        tick();
        out_en = 1'b0;
        tick();
        out_en = 1'b1;
        for (int k = 3; k <= 14; k++) begin
            tick();
            check(wave(4, k - 1), "R6", k);
        end
    endtask

    // R7: select change from 8 to 2 lands on the next boundary.
    task automatic t_sel_8_to_2();
        do_reset(2'b11, 1'b1);
        tick(); tick();
        div_sel = 2'b01;
        for (int k = 3; k <= 16; k++) begin
            tick();
            check((k <= 8) ? wave(8, k - 1) : wave(2, k - 9), "R7", k);
        end
    endtask

    // R7: select change from 4 to 1.
    task automatic t_sel_4_to_1();
        do_reset(2'b10, 1'b1);
        tick();
        div_sel = 2'b00;
        for (int k = 2; k <= 10; k++) begin
            tick();
            check((k <= 4) ? wave(4, k - 1) : 1'b1, "R7", k);
        end
    endtask

    // R3 / R4: divide-by-1 follows the enable one edge later.
    task automatic t_div1_follow();
        logic [11:0] pat;
        pat = 12'b1011_0011_1010;
        do_reset(2'b00, 1'b0);
        for (int k = 0; k < 12; k++) begin
            out_en = pat[k];
            tick();
            check(pat[k], pat[k] ? "R3" : "R4", k);
        end
    endtask

    initial begin
        rst_n   = 1'b0;
        div_sel = 2'b00;
        out_en  = 1'b0;
        for (int s = 0; s < 4; s++) begin
            t_ratio(2'(s));
        end
        t_disable_high();
        t_disable_low();
        t_enable_mid();
        t_enable_dip();
        t_sel_8_to_2();
        t_sel_4_to_1();
        t_div1_follow();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, cycles=%0d expected<%0d", WATCHDOG_CYC, WATCHDOG_CYC);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule